// File: doc/BRIEF.md
# Low-Memory DMA Protection Window

This block guards one region of low system memory against DMA. It holds a base and a limit register that bound the region, plus an enable bit, and on every cycle it can compare an incoming DMA address against the decoded window. A match is reported on a registered hit output one cycle later. The hit output can then be used to block or redirect the transfer.

Only the upper bits of the base and limit are stored. The low reserved bits always read back as zero. When the window is decoded, the base's low bits count as zeros and the limit's low bits count as ones, so the window always starts and ends on aligned block edges. Software finds the alignment by writing all ones to a register and reading it back.

Base and limit can only be written when three conditions hold: the capability strap allows it, the registers are not locked, and protection is not enabled. A lock command freezes them and an unlock command releases them. If the programmed limit lies below the base, the window matches nothing.

Top module: `lowmem_dma_guard`

## Requirements
- R1: After reset, base, limit and enable are zero, the registers are unlocked, and `chkHit` is 0.
- R2: Register select 0 is the base and select 1 is the limit. Bits 31:21 are stored, and bits 20:0 read as zero and ignore writes. For example, writing 0xFFFFFFFF reads back as 0xFFE00000.
- R3: On decode, the base's bits 20:0 are taken as zeros and the limit's bits 20:0 as ones. An address equal to `{limit[31:21], 21'h1FFFFF}` hits, while one past it and one below the decoded base miss.
- R4: `lockCmd` locks the registers. While locked, writes to base and limit are ignored, until `unlockCmd` unlocks them.
- R5: With `capSupport` low, writes to base and limit are ignored and `chkHit` stays 0.
- R6: If base and limit hold equal bits 31:21, the window covers exactly 2^21 bytes starting at the base.
- R7: If the limit's bits 31:21 are below the base's, no address hits.
- R8: While enable is set, writes to base and limit are ignored.
- R9: `chkHit` is registered. It is 1 in the cycle after `chkValid` is high with enable set and the address inside the window, and 0 otherwise.
- R10: If `lockCmd` and `unlockCmd` are asserted in the same cycle, the registers end up locked. A base or limit write in the same cycle as `lockCmd` is dropped.
- R11: Select 2 is the control register. Bit 0 is enable, it is writable whether or not the registers are locked, and it reads as `{31'b0, enable}`. Select 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capSupport | input | 1 | Strap: protected low-memory window is supported |
| lockCmd | input | 1 | Lock base and limit |
| unlockCmd | input | 1 | Unlock base and limit |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 limit, 2 control |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register |
| chkValid | input | 1 | DMA address valid |
| chkAddr | input | 32 | DMA address to check |
| chkHit | output | 1 | Registered hit on the protected window |

## Verification
Directed windows place addresses exactly on the decoded base and limit and one byte on either side of them. These checks separate correct low-bit decoding from an off-by-one or an unmasked compare. Register write-ability is tested under four conditions: locked, enabled, a lock command in the same cycle, and the strap low. Read-back shows whether each write was kept or dropped. Random traffic keeps the upper address bits in a narrow range so that hits, misses and inverted windows all occur often, and a bench model predicts each outcome.

// File: rtl/lmg_pkg.sv
package lmg_pkg;
  typedef struct packed {
    logic wrBase;
    logic wrLimit;
    logic wrCtrl;
  } lmg_strobe_t;
endpackage

// File: rtl/lmg_ctrl.sv
module lmg_ctrl
  import lmg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capSupport,
  input  logic             lockCmd,
  input  logic             unlockCmd,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic             protEn,
  output lmg_strobe_t      strobe,
  output logic             lockQ
);
  localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_CTRL  = SEL_W'(2);

  logic rangeWrOk;

  // base/limit are writable only when supported, unlocked, disabled and not being locked now
  assign rangeWrOk = regWrEn && capSupport && !lockQ && !protEn && !lockCmd;

  always_comb begin
    strobe.wrBase  = rangeWrOk && (regSel == SEL_BASE);
    strobe.wrLimit = rangeWrOk && (regSel == SEL_LIMIT);
    strobe.wrCtrl  = regWrEn && (regSel == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lockQ <= 1'b0;
    else if (lockCmd)   lockQ <= 1'b1;
    else if (unlockCmd) lockQ <= 1'b0;
  end
endmodule

// File: rtl/lmg_datapath.sv
module lmg_datapath
  import lmg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RSVD_W = 21,
  parameter int SEL_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lmg_strobe_t                strobe,
  input  logic [ADDR_W-1:0]          regWrData,
  input  logic [SEL_W-1:0]           regSel,
  input  logic                       capSupport,
  input  logic                       chkValid,
  input  logic [ADDR_W-1:0]          chkAddr,
  output logic [ADDR_W-1:0]          regRdData,
  output logic                       chkHit,
  output logic                       protEn,
  output logic [ADDR_W-RSVD_W-1:0]   baseUp,
  output logic [ADDR_W-RSVD_W-1:0]   limitUp
);
  localparam int UP_W = ADDR_W - RSVD_W;

  logic [ADDR_W-1:0] decBase, decLimit;
  logic              regionOk, hitNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseUp  <= '0;
      limitUp <= '0;
      protEn  <= 1'b0;
    end else begin
      if (strobe.wrBase)  baseUp  <= regWrData[ADDR_W-1:RSVD_W];
      if (strobe.wrLimit) limitUp <= regWrData[ADDR_W-1:RSVD_W];
      if (strobe.wrCtrl)  protEn  <= regWrData[0];
    end
  end

  assign decBase  = {baseUp,  {RSVD_W{1'b0}}};
  assign decLimit = {limitUp, {RSVD_W{1'b1}}};
  assign regionOk = decLimit >= decBase;
  assign hitNext  = chkValid && protEn && capSupport && regionOk &&
                    (chkAddr >= decBase) && (chkAddr <= decLimit);

  always_ff @(posedge clk) begin
    if (!rstN) chkHit <= 1'b0;
    else       chkHit <= hitNext;
  end

  always_comb begin
    case (regSel)
      SEL_W'(0): regRdData = {baseUp,  {RSVD_W{1'b0}}};
      SEL_W'(1): regRdData = {limitUp, {RSVD_W{1'b0}}};
      SEL_W'(2): regRdData = {{(ADDR_W-1){1'b0}}, protEn};
      default:   regRdData = '0;
    endcase
  end

  logic unusedUp;
  assign unusedUp = ^{UP_W{1'b0}};
endmodule

// File: rtl/lowmem_dma_guard.sv
module lowmem_dma_guard
  import lmg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RSVD_W = 21,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capSupport,
  input  logic              lockCmd,
  input  logic              unlockCmd,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              chkValid,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic              chkHit
);
  localparam int UP_W = ADDR_W - RSVD_W;

  lmg_strobe_t     strobe;
  logic            lockQ, protEn;
  logic [UP_W-1:0] baseUp, limitUp;

  lmg_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .capSupport(capSupport), .lockCmd(lockCmd),
    .unlockCmd(unlockCmd), .regWrEn(regWrEn), .regSel(regSel),
    .protEn(protEn), .strobe(strobe), .lockQ(lockQ)
  );

  lmg_datapath #(.ADDR_W(ADDR_W), .RSVD_W(RSVD_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .regSel(regSel), .capSupport(capSupport), .chkValid(chkValid),
    .chkAddr(chkAddr), .regRdData(regRdData), .chkHit(chkHit),
    .protEn(protEn), .baseUp(baseUp), .limitUp(limitUp)
  );
endmodule

// File: rtl/lmg_checker.sv
module lmg_checker #(
  parameter int ADDR_W = 32,
  parameter int RSVD_W = 21,
  parameter int SEL_W  = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     capSupport,
  input logic                     lockCmd,
  input logic                     chkValid,
  input logic                     chkHit,
  input logic [SEL_W-1:0]         regSel,
  input logic [ADDR_W-1:0]        regRdData,
  input logic                     lockQ,
  input logic                     enQ,
  input logic [ADDR_W-RSVD_W-1:0] baseQ,
  input logic [ADDR_W-RSVD_W-1:0] limitQ
);
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regSel < SEL_W'(2)) |-> (regRdData[RSVD_W-1:0] == '0)); // R2
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(baseQ) && $stable(limitQ))); // R4
  AST_NOCAP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !capSupport |=> ($stable(baseQ) && $stable(limitQ))); // R5
  AST_NOCAP_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    chkHit |-> $past(capSupport)); // R5
  AST_INVERTED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    chkHit |-> $past(limitQ >= baseQ)); // R7
  AST_EN_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    enQ |=> ($stable(baseQ) && $stable(limitQ))); // R8
  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    chkHit |-> $past(chkValid && enQ)); // R9
  AST_LOCK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    lockCmd |=> lockQ); // R10
  AST_LOCK_CYCLE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    lockCmd |=> ($stable(baseQ) && $stable(limitQ))); // R10
endmodule

bind lowmem_dma_guard lmg_checker #(.ADDR_W(ADDR_W), .RSVD_W(RSVD_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .capSupport(capSupport), .lockCmd(lockCmd),
  .chkValid(chkValid), .chkHit(chkHit), .regSel(regSel), .regRdData(regRdData),
  .lockQ(lockQ), .enQ(protEn), .baseQ(baseUp), .limitQ(limitUp)
);

// File: tb/lowmem_dma_guard_bench.sv
`timescale 1ns/1ps
module lowmem_dma_guard_bench;
  logic        clk = 0, rstN = 0, capSupport = 1, lockCmd = 0, unlockCmd = 0;
  logic        regWrEn = 0, chkValid = 0;
  logic [1:0]  regSel = 0;
  logic [31:0] regWrData = 0, chkAddr = 0, regRdData;
  logic        chkHit;
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [10:0] mBase = 0, mLimit = 0;
  bit mEn = 0, mLock = 0;

  always #2 clk = ~clk;

  lowmem_dma_guard u_lowmem_dma_guard (
    .clk(clk), .rstN(rstN), .capSupport(capSupport), .lockCmd(lockCmd),
    .unlockCmd(unlockCmd), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .chkValid(chkValid),
    .chkAddr(chkAddr), .chkHit(chkHit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit expHit(input bit cv, input logic [31:0] a);
    logic [31:0] lo, hi;
    lo = {mBase, 21'h0};
    hi = {mLimit, 21'h1FFFFF};
    return cv && mEn && capSupport && (hi >= lo) && (a >= lo) && (a <= hi);
  endfunction

  // one clock: drive at negedge, update model at posedge, check hit at next negedge
  task automatic cyc(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                     input bit lk, input bit ulk, input bit cv, input logic [31:0] a,
                     input string tag);
    bit eh, wrOk;
    regWrEn = wr; regSel = sel; regWrData = d; lockCmd = lk; unlockCmd = ulk;
    chkValid = cv; chkAddr = a;
    eh = expHit(cv, a);
    wrOk = wr && capSupport && !mLock && !mEn && !lk;
    @(posedge clk);
    if (wrOk && sel == 2'd0) mBase = d[31:21];
    if (wrOk && sel == 2'd1) mLimit = d[31:21];
    if (wr && sel == 2'd2) mEn = d[0];
    if (lk) mLock = 1; else if (ulk) mLock = 0;
    @(negedge clk);
    regWrEn = 0; lockCmd = 0; unlockCmd = 0; chkValid = 0;
    check(tag, {31'b0, chkHit}, {31'b0, eh});
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    regSel = sel; regWrEn = 0;
    #0.5;
    check(tag, regRdData, exp);
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    cyc(0, 2'd3, 0, 0, 0, 1, a, tag);
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 base");
    rd(2'd1, 32'h0, "R1 limit");
    rd(2'd2, 32'h0, "R1 ctrl");
    check("R1 hit", {31'b0, chkHit}, 32'h0);
    // R2 reserved bits
    cyc(1, 2'd1, 32'hFFFFFFFF, 0, 0, 0, 0, "R2 wr");
    rd(2'd1, 32'hFFE00000, "R2 limit ones");
    // R3 / R6 exact window of one block
    cyc(1, 2'd0, 32'h004ABCDE, 0, 0, 0, 0, "R3 wr base");
    cyc(1, 2'd1, 32'h00412345, 0, 0, 0, 0, "R3 wr limit");
    rd(2'd0, 32'h00400000, "R2 base read");
    cyc(1, 2'd2, 32'h1, 0, 0, 0, 0, "R11 enable");
    rd(2'd2, 32'h1, "R11 ctrl read");
    rd(2'd3, 32'h0, "R11 sel3");
    probe(32'h00400000, "R6 base edge hit");
    probe(32'h005FFFFF, "R3 limit edge hit");
    probe(32'h00600000, "R6 past end miss");
    probe(32'h003FFFFF, "R3 below base miss");
    cyc(0, 2'd3, 0, 0, 0, 0, 32'h00400000, "R9 no valid");
    // R8 writes ignored while enabled
    cyc(1, 2'd0, 32'h00000000, 0, 0, 0, 0, "R8 wr");
    rd(2'd0, 32'h00400000, "R8 base kept");
    cyc(1, 2'd2, 32'h0, 0, 0, 0, 0, "R11 disable");
    probe(32'h00400000, "R9 disabled miss");
    // R4 lock
    cyc(0, 2'd3, 0, 1, 0, 0, 0, "R4 lock");
    cyc(1, 2'd1, 32'h00E00000, 0, 0, 0, 0, "R4 wr");
    rd(2'd1, 32'h00400000, "R4 limit kept");
    cyc(1, 2'd2, 32'h1, 0, 0, 0, 0, "R11 en while locked");
    rd(2'd2, 32'h1, "R11 en locked read");
    cyc(1, 2'd2, 32'h0, 0, 0, 0, 0, "R11 dis");
    // R10 lock+unlock together stays locked
    cyc(0, 2'd3, 0, 0, 1, 0, 0, "R4 unlock");
    cyc(0, 2'd3, 0, 1, 1, 0, 0, "R10 both");
    cyc(1, 2'd1, 32'h00E00000, 0, 0, 0, 0, "R10 wr");
    rd(2'd1, 32'h00400000, "R10 still locked");
    cyc(0, 2'd3, 0, 0, 1, 0, 0, "R4 unlock2");
    cyc(1, 2'd1, 32'h00E00000, 1, 0, 0, 0, "R10 wr with lock");
    rd(2'd1, 32'h00400000, "R10 dropped");
    cyc(0, 2'd3, 0, 0, 1, 0, 0, "R4 unlock3");
    cyc(1, 2'd1, 32'h00E00000, 0, 0, 0, 0, "R4 wr ok");
    rd(2'd1, 32'h00E00000, "R4 unlocked write");
    // R7 inverted window
    cyc(1, 2'd0, 32'h01000000, 0, 0, 0, 0, "R7 wr");
    cyc(1, 2'd2, 32'h1, 0, 0, 0, 0, "R7 en");
    probe(32'h00E00000, "R7 inverted miss");
    probe(32'h01000000, "R7 inverted miss2");
    cyc(1, 2'd2, 32'h0, 0, 0, 0, 0, "R7 dis");
    // R5 no capability
    capSupport = 0;
    cyc(1, 2'd0, 32'h00000000, 0, 0, 0, 0, "R5 wr");
    rd(2'd0, 32'h01000000, "R5 base kept");
    cyc(1, 2'd1, 32'hFFE00000, 0, 0, 0, 0, "R5 wr2");
    rd(2'd1, 32'h00E00000, "R5 limit kept");
    cyc(1, 2'd2, 32'h1, 0, 0, 0, 0, "R5 en");
    probe(32'h00E00000, "R5 no hit");
    cyc(1, 2'd2, 32'h0, 0, 0, 0, 0, "R5 dis");
    capSupport = 1;
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      rv = {5'b0, 3'($urandom_range(0, 7)), 24'($urandom)};
      case (op)
        0, 1: cyc(1, 2'($urandom_range(0, 1)), rv, 0, 0, 1, rv, "R9 rand wr");
        2:    cyc(1, 2'd2, 32'($urandom_range(0, 1)), 0, 0, 1, rv, "R11 rand en");
        3:    cyc(0, 2'd3, 0, ($urandom_range(0, 3) == 0), 1, 1, rv, "R10 rand lk");
        default: cyc(0, 2'd3, 0, 0, 0, 1, rv, "R3 rand probe");
      endcase
      rd(2'd0, {mBase, 21'h0}, "R2 rand base");
      rd(2'd1, {mLimit, 21'h0}, "R2 rand limit");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule